// File: doc/BRIEF.md
# Addressed Two-Wire Slave Receiver

This block is the receive half of a two-wire (I2C) slave. It watches the synchronised clock and data lines for a START condition, shifts in the 7-bit address and direction bit that follow, and decides whether the header selects it. The header can match either the programmed own address or, when enabled, the all-zero general call address. On a match, and only while software has acknowledgement enabled, it pulls data low through the ninth clock. Each data byte that follows is shifted in, and the same acknowledgement rule decides whether it is acknowledged.

After every acknowledge slot that ends an addressed header or a data byte, the block raises a completion flag. It publishes a status code and the received byte, and holds the clock line low until software clears the flag. Software configures the block through one byte. The upper seven bits are the own address. The lowest bit permits general call recognition. A separate level input enables acknowledgement, and a one-cycle clear pulse retires the flag.

Top module: `twowire_addr_rx`

## Requirements
- R1: After reset both line drivers are released (`sda_drive_low`=0, `scl_hold_low`=0), `done_flag` is 0 and `status_code` is 0xF8.
- R2: A header byte whose bits 7:1 equal `own_addr_cfg[7:1]` and whose bit 0 (direction) is 0 is acknowledged when `ack_en` is 1. The flag then sets with `status_code` 0x60.
- R3: The header 0x00 is acknowledged, with `status_code` 0x70, only when `own_addr_cfg[0]` is 1. Otherwise it is ignored: no acknowledge and no flag.
- R4: With `ack_en` at 0, a matching header gets no acknowledge and does not set the flag.
- R5: Data bits are taken on SCL rising edges, most significant bit first. After an acknowledged byte, `rx_data` holds the byte when the flag sets, with `status_code` 0x80.
- R6: A data byte received while `ack_en` is 0 gets no acknowledge. The flag still sets, with `status_code` 0x88 and the byte in `rx_data`. After the flag is cleared, the block ignores the bus until the next START.
- R7: The flag sets after the falling SCL edge that ends the ninth clock. `scl_hold_low` stays 1 while the flag is pending, and a `flag_clr` pulse clears both.
- R8: A header whose address differs from the own address, or whose direction bit is 1 (read), is not acknowledged and leaves the flag at 0.
- R9: A START seen at any point restarts header reception, so a repeated START is honoured. A STOP returns the block to idle.
- R10: The acknowledge pull-down starts only after the eighth falling SCL edge, is held across the ninth high phase, and is released after the ninth falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| own_addr_cfg | input | 8 | Bits 7:1 own address, bit 0 general call enable |
| ack_en | input | 1 | Acknowledge enable |
| flag_clr | input | 1 | One-cycle pulse that clears the completion flag |
| sda_drive_low | output | 1 | When 1, pull the data line low |
| scl_hold_low | output | 1 | When 1, hold the clock line low |
| done_flag | output | 1 | Completion flag |
| status_code | output | 8 | Code of the last completed event |
| rx_data | output | 8 | Last received data byte |

## Verification
The bench acts as an open-drain bus master. It targets the cases where the recognition decision is easy to get wrong:
- A general call header with recognition disabled. A design that skips the enable bit would answer a broadcast it was told to ignore.
- A read header for the own address. A design that ignores the direction bit would answer it.
- A matching header while acknowledgement is off. A design that does not gate on the enable would claim the bus.

It also probes the acknowledge window on both sides of the ninth clock, and checks that the clock hold survives an attempted master clock rise until the clear pulse. A mistimed slot would show up as a corrupted last data bit or a stuck bus. Finally, it sends a repeated START after a missed header and bytes clocked after a NACK or STOP. A design that keeps stale state there would acknowledge traffic meant for others.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_HOLD
  } twr_state_e;

  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_OWN,
    HIT_GC
  } twr_hit_e;

  localparam logic [7:0] STAT_IDLE      = 8'hF8;
  localparam logic [7:0] STAT_OWN_ACK   = 8'h60;
  localparam logic [7:0] STAT_GC_ACK    = 8'h70;
  localparam logic [7:0] STAT_DATA_ACK  = 8'h80;
  localparam logic [7:0] STAT_DATA_NACK = 8'h88;

  // Decide whether a header byte selects this slave (write direction only).
  function automatic twr_hit_e classify_header(input logic [7:0] hdr, input logic [7:0] cfg);
    if (hdr[0]) return HIT_NONE;
    if (hdr[7:1] == 7'd0) return cfg[0] ? HIT_GC : HIT_NONE;
    if (hdr[7:1] == cfg[7:1]) return HIT_OWN;
    return HIT_NONE;
  endfunction

  function automatic logic [7:0] header_status(input twr_hit_e hit);
    return (hit == HIT_GC) ? STAT_GC_ACK : STAT_OWN_ACK;
  endfunction
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '1;
      else if (g == 0) stage_q[g] <= d;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twowire_addr_rx.sv
module twowire_addr_rx
  import twr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [7:0] own_addr_cfg,
  input  logic       ack_en,
  input  logic       flag_clr,
  output logic       sda_drive_low,
  output logic       scl_hold_low,
  output logic       done_flag,
  output logic [7:0] status_code,
  output logic [7:0] rx_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic scl_rise_evt, scl_fall_evt, start_evt, stop_evt;

  twr_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  twr_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise_evt), .scl_fall(scl_fall_evt),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twr_state_e       state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [7:0]       shreg_q, rx_q, status_q;
  logic             slot_rise_q, ack_now_q, is_hdr_q, resume_q, flag_q, sda_low_q;
  twr_hit_e         hit_q;

  // Named events for the checks below.
  logic [7:0] shifted;
  twr_hit_e   hdr_hit;
  logic       evt_byte_end, evt_flag_set;

  assign shifted      = {shreg_q[6:0], sda_s};
  assign hdr_hit      = classify_header(shifted, own_addr_cfg);
  assign evt_byte_end = scl_rise_evt && (bit_cnt_q == LAST_BIT) &&
                        (state_q == ST_ADDR || state_q == ST_DATA);
  assign evt_flag_set = (state_q == ST_ACK) && scl_fall_evt && slot_rise_q &&
                        !start_evt && !stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      rx_q        <= '0;
      status_q    <= STAT_IDLE;
      slot_rise_q <= 1'b0;
      ack_now_q   <= 1'b0;
      is_hdr_q    <= 1'b0;
      resume_q    <= 1'b0;
      sda_low_q   <= 1'b0;
      hit_q       <= HIT_NONE;
    end else if (start_evt) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      sda_low_q <= 1'b0;
    end else if (stop_evt) begin
      state_q   <= ST_IDLE;
      sda_low_q <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: if (scl_rise_evt) begin
          shreg_q   <= shifted;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST_BIT) begin
            if (hdr_hit != HIT_NONE && ack_en) begin
              state_q     <= ST_ACK;
              ack_now_q   <= 1'b1;
              is_hdr_q    <= 1'b1;
              hit_q       <= hdr_hit;
              slot_rise_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DATA: if (scl_rise_evt) begin
          shreg_q   <= shifted;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST_BIT) begin
            state_q     <= ST_ACK;
            ack_now_q   <= ack_en;
            is_hdr_q    <= 1'b0;
            slot_rise_q <= 1'b0;
          end
        end
        ST_ACK: begin
          if (scl_rise_evt) slot_rise_q <= 1'b1;
          if (scl_fall_evt) begin
            if (!slot_rise_q) begin
              sda_low_q <= ack_now_q;
            end else begin
              sda_low_q <= 1'b0;
              state_q   <= ST_HOLD;
              resume_q  <= ack_now_q;
              if (is_hdr_q) status_q <= header_status(hit_q);
              else begin
                rx_q     <= shreg_q;
                status_q <= ack_now_q ? STAT_DATA_ACK : STAT_DATA_NACK;
              end
            end
          end
        end
        ST_HOLD: if (flag_clr) begin
          state_q   <= resume_q ? ST_DATA : ST_IDLE;
          bit_cnt_q <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (evt_flag_set) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign sda_drive_low = sda_low_q;
  assign scl_hold_low  = (state_q == ST_HOLD);
  assign done_flag     = flag_q;
  assign status_code   = status_q;
  assign rx_data       = rx_q;

  // R10: the pull-down only begins while the clock is low.
  assert_ack_in_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  // R10: never pull data low while stretching the clock.
  assert_no_drive_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_low |-> !sda_drive_low);

  // R7: the flag rises only right after a falling clock edge.
  assert_flag_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(scl_fall_evt));

  // R7: the clock is held only while the flag is pending.
  assert_hold_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_low |-> done_flag);

  // R7: a clear pulse during the hold releases both.
  assert_clear_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && scl_hold_low) |=> (!done_flag && !scl_hold_low));

  // R6: a byte that is not acknowledged never sees the pull-down.
  assert_nack_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && !ack_now_q) |-> !sda_drive_low);

  // R9: a START always restarts header reception.
  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR));

  // R4: a header is only taken when acknowledging is enabled.
  assert_hdr_needs_ack_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && evt_byte_end && !ack_en && !start_evt && !stop_evt) |=> (state_q == ST_IDLE));
endmodule

// File: tb/twowire_addr_rx_tb.sv
module twowire_addr_rx_tb;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] own_addr_cfg = 8'h90;
  logic       ack_en = 1'b1;
  logic       flag_clr = 1'b0;
  logic       sda_drive_low, scl_hold_low, done_flag;
  logic [7:0] status_code, rx_data;
  wire        scl_bus = scl_m & ~scl_hold_low;
  wire        sda_bus = sda_m & ~sda_drive_low;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  twowire_addr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .own_addr_cfg(own_addr_cfg), .ack_en(ack_en), .flag_clr(flag_clr),
    .sda_drive_low(sda_drive_low), .scl_hold_low(scl_hold_low),
    .done_flag(done_flag), .status_code(status_code), .rx_data(rx_data)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit drv_pre, output bit drv_post);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(H);
    drv_pre = sda_drive_low;
    scl_m = 1'b1; tick(H/2);
    acked = !sda_bus;
    tick(H/2);
    scl_m = 1'b0; tick(H);
    drv_post = sda_drive_low;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(1);
    flag_clr = 1'b0; tick(2);
  endtask

  task automatic test_reset();
    check(sda_drive_low == 0 && scl_hold_low == 0, "R1 lines released", {sda_drive_low, scl_hold_low}, 0);
    check(done_flag == 0, "R1 flag clear", done_flag, 0);
    check(status_code == 8'hF8, "R1 status idle", status_code, 8'hF8);
  endtask

  task automatic test_own_write();
    bit a, pre, post;
    own_addr_cfg = 8'h90; ack_en = 1'b1;
    bus_start();
    send_byte(8'h90, a, pre, post);
    check(a, "R2 own header acked", a, 1);
    check(pre && !post, "R10 ack window", {pre, post}, 2'b10);
    check(done_flag, "R2 flag set", done_flag, 1);
    check(status_code == 8'h60, "R2 status", status_code, 8'h60);
    check(scl_hold_low, "R7 clock held", scl_hold_low, 1);
    scl_m = 1'b1; tick(4);
    check(scl_bus == 0, "R7 master cannot raise clock", scl_bus, 0);
    scl_m = 1'b0; tick(2);
    clear_flag();
    check(!done_flag && !scl_hold_low, "R7 clear releases", {done_flag, scl_hold_low}, 0);
    send_byte(8'hF5, a, pre, post);
    check(a, "R5 data acked", a, 1);
    check(rx_data == 8'hF5, "R5 data byte", rx_data, 8'hF5);
    check(status_code == 8'h80, "R5 status", status_code, 8'h80);
    clear_flag();
    send_byte(8'h3C, a, pre, post);
    check(rx_data == 8'h3C && done_flag, "R5 second byte", rx_data, 8'h3C);
    clear_flag();
    bus_stop();
  endtask

  task automatic test_general_call();
    bit a, pre, post;
    own_addr_cfg = 8'h91; ack_en = 1'b1;
    bus_start();
    send_byte(8'h00, a, pre, post);
    check(a && done_flag, "R3 general call acked", {a, done_flag}, 2'b11);
    check(status_code == 8'h70, "R3 status", status_code, 8'h70);
    clear_flag();
    bus_stop();
    own_addr_cfg = 8'h90;
    bus_start();
    send_byte(8'h00, a, pre, post);
    check(!a && !done_flag, "R3 general call ignored when disabled", {a, done_flag}, 0);
    bus_stop();
  endtask

  task automatic test_ack_disabled();
    bit a, pre, post;
    own_addr_cfg = 8'h90; ack_en = 1'b0;
    bus_start();
    send_byte(8'h90, a, pre, post);
    check(!a && !done_flag && !scl_hold_low, "R4 no ack when disabled", {a, done_flag, scl_hold_low}, 0);
    bus_stop();
    ack_en = 1'b1;
  endtask

  task automatic test_data_nack();
    bit a, pre, post;
    own_addr_cfg = 8'h90; ack_en = 1'b1;
    bus_start();
    send_byte(8'h90, a, pre, post);
    clear_flag();
    ack_en = 1'b0;
    send_byte(8'hA5, a, pre, post);
    check(!a && done_flag, "R6 nack with flag", {a, done_flag}, 2'b01);
    check(status_code == 8'h88 && rx_data == 8'hA5, "R6 status and byte", {status_code, rx_data}, 16'h88A5);
    clear_flag();
    ack_en = 1'b1;
    send_byte(8'h5A, a, pre, post);
    check(!a && !done_flag && rx_data == 8'hA5, "R6 ignored after nack", {a, done_flag, rx_data}, 8'hA5);
    bus_stop();
  endtask

  task automatic test_mismatch();
    bit a, pre, post;
    own_addr_cfg = 8'h90; ack_en = 1'b1;
    bus_start();
    send_byte(8'h92, a, pre, post);
    check(!a && !done_flag, "R8 other address ignored", {a, done_flag}, 0);
    bus_stop();
    bus_start();
    send_byte(8'h91, a, pre, post);
    check(!a && !done_flag, "R8 read header ignored", {a, done_flag}, 0);
    bus_stop();
  endtask

  task automatic test_restart();
    bit a, pre, post;
    own_addr_cfg = 8'h90; ack_en = 1'b1;
    bus_start();
    send_byte(8'h92, a, pre, post);
    bus_start();
    send_byte(8'h90, a, pre, post);
    check(a && done_flag && status_code == 8'h60, "R9 repeated start", {a, done_flag}, 2'b11);
    clear_flag();
    bus_stop();
    send_byte(8'h90, a, pre, post);
    check(!a && !done_flag, "R9 idle after stop", {a, done_flag}, 0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    test_reset();
    test_own_write();
    test_general_call();
    test_ack_disabled();
    test_data_nack();
    test_mismatch();
    test_restart();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule